// File: doc/BRIEF.md
# Two-Error-Detecting BCH Word Decoder with Byte-Read Buffer

This block takes 40-bit codewords from an upstream receiver, each made of 28 data bits followed by 12 parity bits of a cyclic code with generator x^12 + x^10 + x^8 + x^5 + x^4 + x^3 + 1. After a one-cycle `wordValid` strobe, the block shifts the word through a 12-bit remainder register, one bit per clock and most significant bit first. A zero remainder means the word is clean. A remainder equal to the syndrome of a single flipped bit means that bit is inverted back. Any other remainder marks the word as uncorrectable, and the word is then stored as received.

The 28 data bits go into a one-word holding buffer. A host drains it with byte reads on a two-register read port. Address 0 returns the status byte and address 1 returns the next data byte. Loading the buffer raises an interrupt, and the interrupt stays high until the status byte is read. A word that arrives while the decoder is busy, or while the buffer still holds unread bytes, is discarded and recorded as missed.

Top module: `bch_rx_buffer`

## Requirements
- R1: After reset `irq` is low and the status byte reads 0x00.
- R2: A codeword with a zero remainder is stored with its 28 data bits unchanged, and the uncorrectable flag (status bit 1) stays 0.
- R3: A codeword with exactly one flipped bit, at any of the 40 positions, is stored with the original data and with status bit 1 at 0.
- R4: A codeword with two flipped bits sets status bit 1 and is stored uncorrected.
- R5: Four data reads (address 1) return data bits 27:20, 19:12, 11:4, and then bits 3:0 in the upper nibble with a zero lower nibble, in that order.
- R6: When a word is committed to the buffer, status bit 0 (ready) is set and `irq` goes high. A status read (address 0) returns the status before the read and then clears `irq` and status bit 2.
- R7: A `wordValid` strobe that arrives while the buffer is ready or the decoder is busy (status bit 3) drops the new word, sets status bit 2 (missed), and leaves the buffered bytes unchanged.
- R8: The fourth data read clears ready. After that, a new word is accepted and its read sequence starts again at its first byte.
- R9: `irq` rises exactly 41 clock edges after the edge that samples `wordValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | One-cycle strobe: `wordIn` holds a new codeword |
| wordIn | input | 40 | Codeword, data in bits 39:12, parity in bits 11:0 |
| rdEn | input | 1 | Read strobe; side effects take place at the clock edge |
| rdAddr | input | 1 | 0 selects status, 1 selects data |
| rdData | output | 8 | Read data for the selected register, valid while `rdEn` is high |
| irq | output | 1 | High from buffer load until the next status read |

## Verification
Several data words are encoded in the bench and sent clean, with one flipped bit at the top or bottom position, and with two flipped bits. These cases separate an untouched word from a corrected word and from a flagged word. A sweep flips each of the 40 positions in turn, so that any wrong or missing entry in the single-error match set is found. Two overrun cases follow. One sends a word during decoding and the other sends a word into a full buffer, which checks the drop rule against both busy conditions. A latency probe fixes the exact edge on which `irq` rises.

// File: rtl/bch_pkg.sv
package bch_pkg;
  localparam int DATA_W = 28;
  localparam int PAR_W  = 12;
  localparam int WORD_W = DATA_W + PAR_W;
  localparam logic [PAR_W-1:0] GEN_LOW = 12'h539;

  typedef struct packed {
    logic load;
    logic shift;
    logic commit;
    logic advance;
  } bchStrobes_t;
endpackage

// File: rtl/bch_ctrl.sv
module bch_ctrl
  import bch_pkg::*;
#(
  parameter int N = WORD_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wordValid,
  input  logic        rdEn,
  input  logic        rdAddr,
  input  logic        lastByte,
  input  logic        uncorrIn,
  output bchStrobes_t strobes,
  output logic [7:0]  statusByte,
  output logic        irq
);
  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_COMMIT} state_t;
  state_t state;
  logic [CW-1:0] cnt;
  logic full, missed, uncorr, busy, accept, statusRd, dataRd;

  assign busy     = (state != S_IDLE);
  assign accept   = wordValid && !busy && !full;
  assign statusRd = rdEn && !rdAddr;
  assign dataRd   = rdEn && rdAddr;

  always_comb begin
    strobes.load    = accept;
    strobes.shift   = (state == S_SHIFT);
    strobes.commit  = (state == S_COMMIT);
    strobes.advance = dataRd && full;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state <= S_SHIFT;
          cnt   <= '0;
        end
        S_SHIFT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= S_COMMIT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      full   <= 1'b0;
      irq    <= 1'b0;
      missed <= 1'b0;
      uncorr <= 1'b0;
    end else begin
      if (strobes.commit) full <= 1'b1;
      else if (strobes.advance && lastByte) full <= 1'b0;

      if (strobes.commit) irq <= 1'b1;
      else if (statusRd) irq <= 1'b0;

      if (wordValid && !accept) missed <= 1'b1;
      else if (statusRd) missed <= 1'b0;

      if (strobes.commit) uncorr <= uncorrIn;
    end
  end

  assign statusByte = {4'b0000, busy, missed, uncorr, full};
endmodule

// File: rtl/bch_dp.sv
module bch_dp
  import bch_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PAR_W,
  parameter logic [PW-1:0] GEN = GEN_LOW
) (
  input  logic           clk,
  input  logic           rstN,
  input  bchStrobes_t    strobes,
  input  logic [DW+PW-1:0] wordIn,
  output logic [7:0]     dataByte,
  output logic           lastByte,
  output logic           uncorr
);
  localparam int N = DW + PW;
  localparam int NB = (DW + 7) / 8;
  localparam int PADW = NB * 8;

  logic [N-1:0]  rotReg;
  logic [PW-1:0] syn;
  logic [DW-1:0] bufData;
  logic [1:0]    ptr;
  logic [N-1:0]  fixMask;
  logic          hit;

  always_comb begin
    logic [PW-1:0] pat;
    pat = PW'(1);
    fixMask = '0;
    hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (syn == pat) begin
        fixMask[i] = 1'b1;
        hit = 1'b1;
      end
      pat = pat[PW-1] ? ({pat[PW-2:0], 1'b0} ^ GEN) : {pat[PW-2:0], 1'b0};
    end
  end

  assign uncorr = (syn != '0) && !hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rotReg  <= '0;
      syn     <= '0;
      bufData <= '0;
      ptr     <= '0;
    end else begin
      if (strobes.load) begin
        rotReg <= wordIn;
        syn    <= '0;
      end else if (strobes.shift) begin
        rotReg <= {rotReg[N-2:0], rotReg[N-1]};
        syn    <= {syn[PW-2:0], rotReg[N-1]} ^ (syn[PW-1] ? GEN : '0);
      end
      if (strobes.commit) begin
        bufData <= (rotReg ^ (uncorr ? '0 : fixMask)) >> PW;
        ptr     <= '0;
      end else if (strobes.advance) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  logic [PADW-1:0] padded;
  assign padded   = {bufData, {(PADW - DW){1'b0}}};
  assign dataByte = padded[PADW-1 - 8*ptr -: 8];
  assign lastByte = (ptr == 2'(NB - 1));
endmodule

// File: rtl/bch_rx_buffer.sv
module bch_rx_buffer
  import bch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wordValid,
  input  logic [39:0] wordIn,
  input  logic        rdEn,
  input  logic        rdAddr,
  output logic [7:0]  rdData,
  output logic        irq
);
  bchStrobes_t strobes;
  logic [7:0]  statusByte, dataByte;
  logic        lastByte, uncorr;

  bch_ctrl #(.N(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .rdEn(rdEn), .rdAddr(rdAddr),
    .lastByte(lastByte), .uncorrIn(uncorr), .strobes(strobes),
    .statusByte(statusByte), .irq(irq)
  );

  bch_dp #(.DW(DATA_W), .PW(PAR_W), .GEN(GEN_LOW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wordIn(wordIn),
    .dataByte(dataByte), .lastByte(lastByte), .uncorr(uncorr)
  );

  assign rdData = rdAddr ? dataByte : statusByte;
endmodule

// File: rtl/bch_rx_checker.sv
module bch_rx_checker (
  input logic clk,
  input logic rstN,
  input logic wordValid,
  input logic rdEn,
  input logic rdAddr,
  input logic irq,
  input logic commit,
  input logic full,
  input logic busy,
  input logic missed
);
  a_r6_irq_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rdAddr && !commit) |=> !irq);

  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(commit));

  a_r6_commit_ready: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> (full && irq));

  a_r7_missed_set: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && (full || busy)) |=> missed);

  a_r7_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (full && !(rdEn && rdAddr)) |=> full);
endmodule

bind bch_rx_buffer bch_rx_checker u_chk (
  .clk(clk), .rstN(rstN), .wordValid(wordValid), .rdEn(rdEn), .rdAddr(rdAddr),
  .irq(irq), .commit(strobes.commit), .full(statusByte[0]),
  .busy(statusByte[3]), .missed(statusByte[2])
);

// File: tb/bch_rx_buffer_tb.sv
module bch_rx_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {data28, error mask 40, expected uncorrectable}
  localparam logic [68:0] VECS [NVEC] = '{
    {28'h0000000, 40'h0, 1'b0},
    {28'hABCDEF1, 40'h0, 1'b0},
    {28'h1234567, 40'h8000000000, 1'b0},
    {28'hFFFFFFF, 40'h0000000001, 1'b0},
    {28'h5A5A5A5, 40'h0000000003, 1'b1},
    {28'h0F0F0F0, 40'h0040000020, 1'b1},
    {28'h7654321, 40'hC000000000, 1'b1}
  };

  logic clk = 0, rstN = 0, wordValid = 0, rdEn = 0, rdAddr = 0;
  logic [39:0] wordIn = '0;
  logic [7:0] rdData;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bch_rx_buffer u_dut (.clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .irq(irq));

  function automatic logic [39:0] encode(logic [27:0] d);
    logic [11:0] r = '0;
    logic [39:0] m = {d, 12'h000};
    for (int i = 39; i >= 0; i--) begin
      logic fb = r[11];
      r = {r[10:0], m[i]} ^ (fb ? 12'h539 : 12'h000);
    end
    return {d, r};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendWord(logic [39:0] w);
    @(negedge clk); wordValid = 1; wordIn = w;
    @(negedge clk); wordValid = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    @(negedge clk); rdEn = 1; rdAddr = a;
    #1 v = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic readWord(output logic [31:0] v);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      rd(1'b1, b);
      v = {v[23:0], b};
    end
  endtask

  task automatic decodeCase(logic [27:0] d, logic [39:0] err, logic expU, string req);
    logic [7:0] st;
    logic [31:0] got;
    sendWord(encode(d) ^ err);
    repeat (45) @(negedge clk);
    check(irq === 1'b1, req, irq, 1);
    rd(1'b0, st);
    check(st === {6'b0, expU, 1'b1}, req, st, {6'b0, expU, 1'b1});
    readWord(got);
    if (!expU) check(got === {d, 4'h0}, req, got, {d, 4'h0});
    else check(got === {(encode(d) ^ err) >> 12, 4'h0}, req, got, {(encode(d) ^ err) >> 12, 4'h0});
    rd(1'b0, st);
    check(st[0] === 1'b0 && irq === 1'b0, "R8 ready cleared", {st, 7'b0, irq}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    logic [31:0] got;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(irq === 1'b0, "R1 irq", irq, 0);
    rd(1'b0, st);
    check(st === 8'h00, "R1 status", st, 0);

    // R2 R3 R4 R5 table walk
    for (int v = 0; v < NVEC; v++)
      decodeCase(VECS[v][68:41], VECS[v][40:1], VECS[v][0], "R2/R3/R4/R5 vector");

    // R3 sweep of every single-bit position
    for (int p = 0; p < 40; p++)
      decodeCase(28'h9C3E1B7 ^ 28'(p), 40'h1 << p, 1'b0, "R3 sweep");

    // R9 latency
    sendWord(encode(28'h1111111));
    repeat (40) @(negedge clk);
    check(irq === 1'b0, "R9 not early", irq, 0);
    @(negedge clk);
    check(irq === 1'b1, "R9 on time", irq, 1);

    // R7 overrun while full
    sendWord(encode(28'h2222222));
    repeat (45) @(negedge clk);
    rd(1'b0, st);
    check(st === 8'h05, "R7 missed while full", st, 8'h05);
    rd(1'b0, st);
    check(st === 8'h01 && irq === 1'b0, "R6 status read clears missed and irq", {st, 7'b0, irq}, 16'h0100);
    readWord(got);
    check(got === {28'h1111111, 4'h0}, "R7 buffer unchanged", got, {28'h1111111, 4'h0});

    // R7 overrun while busy
    sendWord(encode(28'h3333333));
    repeat (5) @(negedge clk);
    sendWord(encode(28'h4444444));
    repeat (45) @(negedge clk);
    rd(1'b0, st);
    check(st === 8'h05, "R7 missed while busy", st, 8'h05);
    readWord(got);
    check(got === {28'h3333333, 4'h0}, "R7 busy drop kept first", got, {28'h3333333, 4'h0});

    // R8 new word starts at its first byte after a full drain
    decodeCase(28'h89ABCDE, 40'h0, 1'b0, "R8 restart");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule